// File: doc/BRIEF.md
# Rise-Time Pixel Digitizer with Per-Pixel Calibration

This block turns the readout of a slow sensor array into grey levels. Each pixel readout begins when the pixel reset strobe is released. From that moment a timer counts clock cycles until a comparator on the shared column line reports that the line has crossed its sense threshold. A dark pixel draws less photocurrent than a light one, so it takes longer to trip the comparator. The counted time is the raw pixel measurement.

The spread between a fully dark and a fully light pixel is small: the ratio of the two times can be as low as about 1.4. Pixels also differ from one another. For these reasons the block keeps two reference times for every pixel. One comes from a frame of pure black and one from a frame of pure white. Both are captured in calibration modes before any image is taken. In image mode each measured time is placed on a line between that pixel's own black and white references. A small iterative divider then produces an 8-bit grey level, and a one-cycle valid strobe marks the result.

The caller presents the pixel index, the readout window length and the mode while the reset strobe is high. The block latches these values on the first clock that samples the strobe low. Successive pixel completions must be at least 26 cycles apart, so that the divider is free when the next result arrives.

Top module: `risetime_grey_digitizer`

## Requirements
- R1: After `rst_n` is deasserted, `grey` reads 0 and `grey_vld` is low until the first image result.
- R2: The measured time t is the number of clock edges, after the edge that first samples `pix_rst` low, on which `cmp_trip` is sampled low. Measurement ends on the edge that samples `cmp_trip` high. For a pixel with dark reference B and light reference W, where W < B and W < t < B, `grey` = floor(255·(B − t)/(B − W)).
- R3: `grey_vld` is high for exactly one cycle per image-mode pixel. It rises on the 25th rising edge after the edge that ends the measurement, and `grey` holds that result from then on.
- R4: The mode codes are as follows. 0 is image. 1 stores t as the pixel's dark reference. 2 stores t as the pixel's light reference. 3 stores nothing and produces no result. Modes 1, 2 and 3 never raise `grey_vld`. A store touches only the addressed pixel and only the reference named by the mode.
- R5: In image mode, t ≥ B gives `grey` = 0 and t ≤ W gives `grey` = 255.
- R6: If `cmp_trip` has not been sampled high once t reaches the latched window length, measurement ends with t equal to the window. In image mode the pixel then reads 0, as black. In a calibration mode the window value is stored as the reference.
- R7: A pixel whose light reference is not below its dark reference is defective. It reads 128 in image mode, and this takes priority over R5 and R6.
- R8: Mode, pixel index and window are latched on the edge that first samples `pix_rst` low. Changing them during the measurement has no effect on that pixel's result or on the references of any other pixel.
- R9: Raising `pix_rst` during a measurement abandons it with no result and no store. Timing restarts from the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_rst | input | 1 | Pixel reset strobe; its release starts the timer |
| cmp_trip | input | 1 | Column comparator output, high once the threshold is crossed |
| pix_idx | input | 10 | Pixel index, latched at release |
| win_len | input | 16 | Readout window length in cycles, latched at release |
| mode | input | 2 | 0 image, 1 store dark reference, 2 store light reference, 3 no action |
| grey | output | 8 | Grey level of the last image pixel |
| grey_vld | output | 1 | One-cycle strobe marking a new grey level |

## Verification
A result cannot appear until the timer has ended a measurement. The end falls on the (t+1)th edge after the edge that samples the strobe low, and the stores then land one edge later. The grey strobe follows 25 edges after the end of measurement: one edge to look up references and load the divider, and 24 shift steps. For each pixel the bench counts rising edges from the edge that ends the measurement. It samples one nanosecond after each edge, and it requires the strobe first on count 25 and with the predicted grey level. In calibration and no-action modes it watches the same window and requires that no strobe appears. Each stored reference is then checked through a later image-mode readout.

// File: rtl/rg_pkg.sv
package rg_pkg;

   typedef enum logic [1:0] {
      RG_MODE_IMAGE     = 2'd0,
      RG_MODE_CAL_DARK  = 2'd1,
      RG_MODE_CAL_LIGHT = 2'd2,
      RG_MODE_HOLD      = 2'd3
   } rg_mode_e;

   localparam int RG_BANK_DARK  = 0;
   localparam int RG_BANK_LIGHT = 1;
   localparam int RG_BANKS      = 2;

endpackage

// File: rtl/rg_rise_timer.sv
// Counts cycles from the release of the pixel reset strobe until the
// comparator trips or the latched window runs out.
module rg_rise_timer #(
   parameter int TIME_W = 16,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_rst,
   input  logic              cmp_trip,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic [1:0]        mode_in,
   input  logic [TIME_W-1:0] win_in,
   output logic              done_o,
   output logic [TIME_W-1:0] time_o,
   output logic              tmo_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [1:0]        mode_o
);

   localparam logic [TIME_W-1:0] CNT_MAX = '1;

   logic              rst_q;
   logic              meas;
   logic [TIME_W-1:0] cnt;
   logic [TIME_W-1:0] win_l;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_q  <= 1'b0;
         meas   <= 1'b0;
         cnt    <= '0;
         win_l  <= '0;
         done_o <= 1'b0;
         time_o <= '0;
         tmo_o  <= 1'b0;
         idx_o  <= '0;
         mode_o <= '0;
      end else begin
         done_o <= 1'b0;
         rst_q  <= pix_rst;
         if (pix_rst) begin
            meas <= 1'b0;
         end else if (rst_q) begin
            meas   <= 1'b1;
            cnt    <= '0;
            win_l  <= win_in;
            idx_o  <= idx_in;
            mode_o <= mode_in;
         end else if (meas) begin
            if (cmp_trip) begin
               done_o <= 1'b1;
               time_o <= cnt;
               tmo_o  <= 1'b0;
               meas   <= 1'b0;
            end else if (cnt >= win_l) begin
               done_o <= 1'b1;
               time_o <= win_l;
               tmo_o  <= 1'b1;
               meas   <= 1'b0;
            end else begin
               cnt <= (cnt == CNT_MAX) ? CNT_MAX : cnt + TIME_W'(1);
            end
         end
      end
   end

   // R6: a finished measurement never exceeds the latched window
   a_r6_time_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (time_o <= win_l));

   // R9: a strobe held high leaves no completion on the next cycle
   a_r9_strobe_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
      pix_rst |=> !done_o);

endmodule

// File: rtl/rg_ref_bank.sv
// One bank of per-pixel reference times: synchronous write, combinational read.
module rg_ref_bank #(
   parameter int DEPTH  = 1024,
   parameter int IDX_W  = 10,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [TIME_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [TIME_W-1:0] rd_data
);

   logic [TIME_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_addr) < DEPTH)) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;

   // R4: a store is visible at its address on the following cycle
   a_r4_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) < DEPTH)) |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/rg_ratio_divider.sv
// Restoring divider, one quotient bit per cycle, fixed latency,
// with the quotient clamped to the output width and an override value.
module rg_ratio_divider #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 16,
   parameter int Q_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   input  logic             force_en,
   input  logic [Q_W-1:0]   force_val,
   output logic             busy,
   output logic [Q_W-1:0]   q,
   output logic             q_vld
);

   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] quo;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] dvs;
   logic [CNT_W-1:0] iter;
   logic             f_en;
   logic [Q_W-1:0]   f_val;

   logic [DEN_W:0]   rem_sh;
   logic             fits;
   logic [DEN_W:0]   rem_nx;
   logic [NUM_W-1:0] quo_nx;
   logic [Q_W-1:0]   q_clamped;
   logic             unused_rem_msb;

   always_comb begin
      rem_sh = {rem, quo[NUM_W-1]};
      fits   = rem_sh >= {1'b0, dvs};
      rem_nx = fits ? (rem_sh - {1'b0, dvs}) : rem_sh;
      quo_nx = {quo[NUM_W-2:0], fits};
   end

   assign unused_rem_msb = rem_nx[DEN_W];

   generate
      if (NUM_W > Q_W) begin : g_clamp
         assign q_clamped = (|quo_nx[NUM_W-1:Q_W]) ? '1 : quo_nx[Q_W-1:0];
      end else begin : g_pass
         assign q_clamped = Q_W'(quo_nx);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo   <= '0;
         rem   <= '0;
         dvs   <= '0;
         iter  <= '0;
         busy  <= 1'b0;
         f_en  <= 1'b0;
         f_val <= '0;
         q     <= '0;
         q_vld <= 1'b0;
      end else begin
         q_vld <= 1'b0;
         if (busy) begin
            quo  <= quo_nx;
            rem  <= rem_nx[DEN_W-1:0];
            iter <= iter - CNT_W'(1);
            if (iter == CNT_W'(1)) begin
               busy  <= 1'b0;
               q_vld <= 1'b1;
               q     <= f_en ? f_val : q_clamped;
            end
         end else if (start) begin
            quo   <= num;
            rem   <= '0;
            dvs   <= den;
            iter  <= CNT_W'(NUM_W);
            busy  <= 1'b1;
            f_en  <= force_en;
            f_val <= force_val;
         end
      end
   end

   // R3: the result strobe lasts one cycle
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      q_vld |=> !q_vld);

   // R2: the partial remainder stays below a non-zero divisor
   a_r2_remainder_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (dvs != '0)) |-> (rem < dvs));

endmodule

// File: rtl/risetime_grey_digitizer.sv
module risetime_grey_digitizer
   import rg_pkg::*;
#(
   parameter int TIME_W    = 16,
   parameter int IDX_W     = 10,
   parameter int PIX_COUNT = 1024,
   parameter int GREY_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_rst,
   input  logic              cmp_trip,
   input  logic [IDX_W-1:0]  pix_idx,
   input  logic [TIME_W-1:0] win_len,
   input  logic [1:0]        mode,
   output logic [GREY_W-1:0] grey,
   output logic              grey_vld
);

   localparam int               NUM_W    = TIME_W + GREY_W;
   localparam logic [GREY_W-1:0] MID_GREY = GREY_W'(1) << (GREY_W - 1);

   initial begin
      assert (TIME_W >= 8) else $error("TIME_W too small");
      assert (GREY_W >= 2 && GREY_W <= 16) else $error("GREY_W out of range");
      assert (PIX_COUNT >= 2 && PIX_COUNT <= (1 << IDX_W)) else $error("PIX_COUNT does not fit IDX_W");
   end

   // timer
   logic              t_done;
   logic [TIME_W-1:0] t_time;
   logic              t_tmo;
   logic [IDX_W-1:0]  t_idx;
   logic [1:0]        t_mode;

   rg_rise_timer #(.TIME_W(TIME_W), .IDX_W(IDX_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .pix_rst (pix_rst),
      .cmp_trip(cmp_trip),
      .idx_in  (pix_idx),
      .mode_in (mode),
      .win_in  (win_len),
      .done_o  (t_done),
      .time_o  (t_time),
      .tmo_o   (t_tmo),
      .idx_o   (t_idx),
      .mode_o  (t_mode)
   );

   rg_mode_e job_mode;
   assign job_mode = rg_mode_e'(t_mode);

   // reference banks
   logic [TIME_W-1:0]   ref_rd [RG_BANKS];
   logic [RG_BANKS-1:0] bank_we;

   generate
      for (genvar b = 0; b < RG_BANKS; b++) begin : g_bank
         localparam rg_mode_e BANK_MODE = (b == RG_BANK_DARK) ? RG_MODE_CAL_DARK : RG_MODE_CAL_LIGHT;
         assign bank_we[b] = t_done && (job_mode == BANK_MODE);
         rg_ref_bank #(.DEPTH(PIX_COUNT), .IDX_W(IDX_W), .TIME_W(TIME_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bank_we[b]),
            .wr_addr(t_idx),
            .wr_data(t_time),
            .rd_addr(t_idx),
            .rd_data(ref_rd[b])
         );
      end
   endgenerate

   // classification and division operands
   logic [TIME_W-1:0] ref_dark, ref_light, span, diff;
   logic              px_defect, px_dark, px_light;
   logic [TIME_W-1:0] div_den;
   logic [NUM_W-1:0]  div_num;
   logic              div_load, div_busy;

   always_comb begin
      ref_dark  = ref_rd[RG_BANK_DARK];
      ref_light = ref_rd[RG_BANK_LIGHT];
      px_defect = ref_light >= ref_dark;
      px_dark   = t_tmo || (t_time >= ref_dark);
      px_light  = t_time <= ref_light;
      span      = ref_dark - ref_light;
      if (px_defect || px_dark) begin
         diff = '0;
      end else if (px_light) begin
         diff = span;
      end else begin
         diff = ref_dark - t_time;
      end
      div_den = px_defect ? TIME_W'(1) : span;
      div_num = {diff, {GREY_W{1'b0}}} - NUM_W'(diff);
   end

   assign div_load = t_done && (job_mode == RG_MODE_IMAGE) && !div_busy;

   // per-job flags, kept beside the divider for checking
   logic job_defect, job_dark, job_light;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         job_defect <= 1'b0;
         job_dark   <= 1'b0;
         job_light  <= 1'b0;
      end else if (div_load) begin
         job_defect <= px_defect;
         job_dark   <= px_dark && !px_defect;
         job_light  <= px_light && !px_dark && !px_defect;
      end
   end

   rg_ratio_divider #(.NUM_W(NUM_W), .DEN_W(TIME_W), .Q_W(GREY_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_load),
      .num      (div_num),
      .den      (div_den),
      .force_en (px_defect),
      .force_val(MID_GREY),
      .busy     (div_busy),
      .q        (grey),
      .q_vld    (grey_vld)
   );

   // R7: defective pixels read mid-scale
   a_r7_defect_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (grey_vld && job_defect) |-> (grey == MID_GREY));

   // R5 / R6: dark or timed-out pixels read zero
   a_r5_dark_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (grey_vld && job_dark) |-> (grey == '0));

   // R5: pixels at or above the light reference read full scale
   a_r5_light_full: assert property (@(posedge clk) disable iff (!rst_n)
      (grey_vld && job_light) |-> (grey == '1));

   // R4: calibration completions never start a result
   a_r4_cal_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (t_done && (job_mode != RG_MODE_IMAGE)) |-> !div_load);

endmodule

// File: tb/risetime_grey_digitizer_test.sv
`timescale 1ns/100ps
module risetime_grey_digitizer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_rst = 1'b0;
   logic        cmp_trip = 1'b0;
   logic [9:0]  pix_idx = '0;
   logic [15:0] win_len = '0;
   logic [1:0]  mode = '0;
   logic [7:0]  grey;
   logic        grey_vld;

   int checks = 0;
   int errors = 0;
   int vld_seen = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   risetime_grey_digitizer uut (
      .clk(clk), .rst_n(rst_n), .pix_rst(pix_rst), .cmp_trip(cmp_trip),
      .pix_idx(pix_idx), .win_len(win_len), .mode(mode),
      .grey(grey), .grey_vld(grey_vld)
   );

   always @(negedge clk) if (grey_vld) vld_seen++;

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int exp_grey(input int b, input int w, input int t, input bit tmo);
      if (w >= b) return 128;
      if (tmo || t >= b) return 0;
      if (t <= w) return 255;
      return (255 * (b - t)) / (b - w);
   endfunction

   // release the strobe; returns just after the start edge
   task automatic begin_px(input int m, input int idx, input int win);
      @(negedge clk);
      pix_rst = 1'b1; mode = 2'(m); pix_idx = 10'(idx); win_len = 16'(win);
      @(negedge clk);
      pix_rst = 1'b0;
      @(posedge clk);
      #1;
   endtask

   // T low edges, then the ending edge; observe 40 edges afterwards
   task automatic finish_px(input int t, input bit hit, output int lat, output int g, output int nv);
      int base;
      repeat (t) @(posedge clk);
      if (hit) begin
         @(negedge clk);
         cmp_trip = 1'b1;
      end
      @(posedge clk);
      #1;
      cmp_trip = 1'b0;
      base = vld_seen;
      lat = 0; g = -1;
      for (int n = 1; n <= 40; n++) begin
         @(posedge clk);
         #1;
         if (grey_vld && lat == 0) begin
            lat = n; g = int'(grey);
         end
      end
      nv = vld_seen - base;
   endtask

   task automatic cal_px(input string req, input int m, input int idx, input int win, input int t, input bit hit);
      int lat, g, nv;
      begin_px(m, idx, win);
      finish_px(t, hit, lat, g, nv);
      chk(req, nv, 0);
   endtask

   task automatic img_px(input string req, input int idx, input int t, input int exp);
      int lat, g, nv;
      begin_px(0, idx, 1000);
      finish_px(t, 1'b1, lat, g, nv);
      chk(req, g, exp);
   endtask

   task automatic t_reset;
      chk("R1 grey after reset", int'(grey), 0);
      chk("R1 valid after reset", int'(grey_vld), 0);
   endtask

   task automatic t_calibrate;
      cal_px("R4 dark store silent", 1, 5, 1000, 300, 1'b1);
      cal_px("R4 light store silent", 2, 5, 1000, 200, 1'b1);
      cal_px("R4 dark store silent", 1, 9, 1000, 140, 1'b1);
      cal_px("R4 light store silent", 2, 9, 1000, 100, 1'b1);
      cal_px("R4 store silent", 1, 20, 1000, 100, 1'b1);
      cal_px("R4 store silent", 2, 20, 1000, 100, 1'b1);
      cal_px("R4 store silent", 1, 21, 1000, 90, 1'b1);
      cal_px("R4 store silent", 2, 21, 1000, 120, 1'b1);
      cal_px("R6 timeout store silent", 1, 30, 180, 180, 1'b0);
      cal_px("R4 store silent", 2, 30, 1000, 100, 1'b1);
   endtask

   task automatic t_interp;
      int lat, g, nv;
      img_px("R2 pixel5 t250", 5, 250, exp_grey(300, 200, 250, 0));
      img_px("R2 pixel5 t210", 5, 210, exp_grey(300, 200, 210, 0));
      begin_px(0, 9, 1000);
      finish_px(130, 1'b1, lat, g, nv);
      chk("R2 pixel9 t130", g, exp_grey(140, 100, 130, 0));
      chk("R3 latency", lat, 25);
      chk("R3 one strobe", nv, 1);
   endtask

   task automatic t_clamp;
      img_px("R5 at dark ref", 5, 300, 0);
      img_px("R5 beyond dark ref", 5, 350, 0);
      img_px("R5 at light ref", 5, 200, 255);
      img_px("R5 beyond light ref", 5, 150, 255);
   endtask

   task automatic t_timeout;
      int lat, g, nv;
      begin_px(0, 5, 280);
      finish_px(280, 1'b0, lat, g, nv);
      chk("R6 image timeout black", g, 0);
      chk("R6 image timeout latency", lat, 25);
      img_px("R6 window stored as ref", 30, 140, exp_grey(180, 100, 140, 0));
   endtask

   task automatic t_defect;
      img_px("R7 equal refs", 20, 100, 128);
      img_px("R7 inverted refs", 21, 50, 128);
   endtask

   task automatic t_latch;
      int lat, g, nv;
      begin_px(0, 9, 1000);
      mode = 2'd1; pix_idx = 10'd5; win_len = 16'd10;
      finish_px(130, 1'b1, lat, g, nv);
      chk("R8 latched inputs used", g, exp_grey(140, 100, 130, 0));
      img_px("R8 other pixel untouched", 5, 250, exp_grey(300, 200, 250, 0));
   endtask

   task automatic t_restart;
      int lat, g, nv;
      begin_px(0, 9, 1000);
      repeat (60) @(posedge clk);
      begin_px(0, 9, 1000);
      finish_px(130, 1'b1, lat, g, nv);
      chk("R9 restart value", g, exp_grey(140, 100, 130, 0));
      chk("R9 single result", nv, 1);
      chk("R9 restart latency", lat, 25);
   endtask

   task automatic t_hold_mode;
      cal_px("R4 mode3 silent", 3, 9, 1000, 40, 1'b1);
      img_px("R4 mode3 no store", 9, 130, exp_grey(140, 100, 130, 0));
   endtask

   task automatic wrap_up;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_calibrate();
      t_interp();
      t_clamp();
      t_timeout();
      t_defect();
      t_latch();
      t_restart();
      t_hold_mode();
      done_flag = 1;
      wrap_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         wrap_up();
      end
   end

endmodule